// File: doc/BRIEF.md
# Integer Execute Unit with Immediates

This block is the purely combinational execute stage for a compact 32-bit load/store integer subset. It receives two register operands (a first source and a second source), a 16-bit immediate field and a 3-bit operation select. From these it produces one 32-bit result. The supported operations are register add and subtract, add-immediate, signed set-less-than in register and immediate forms, AND-immediate, OR-immediate and load-upper-immediate.

Two further outputs are always valid, whatever the operation select. The first is an effective byte address for word and byte loads and stores, computed as the first source plus the sign-extended immediate. The second is an equality flag for equal and not-equal branch tests, raised when the first source minus the second source is zero. Instruction decode, the register file, memory and overflow traps belong to other blocks. A complete 32-bit constant is built by issuing load-upper-immediate and then OR-immediate with the low half.

Top module: `exu_core`

## Requirements
- R1: With op_sel = 0 (add), result equals src_a + src_b modulo 2^32. Carry out is dropped and no trap is raised.
- R2: With op_sel = 1 (subtract), result equals src_a - src_b modulo 2^32.
- R3: With op_sel = 2 (add-immediate), result equals src_a plus the immediate sign-extended from bit 15, modulo 2^32.
- R4: With op_sel = 3 (set-less-than), result is 1 when src_a is below src_b as two's-complement signed numbers, and 0 otherwise. Bits 31:1 of result are always zero.
- R5: With op_sel = 4 (set-less-than-immediate), result is 1 when src_a is signed-less than the sign-extended immediate, and 0 otherwise.
- R6: With op_sel = 5 (AND-immediate), result is src_a AND the zero-extended immediate, so bits 31:16 of result are zero.
- R7: With op_sel = 6 (OR-immediate), result is src_a OR the zero-extended immediate, so bits 31:16 equal those of src_a.
- R8: With op_sel = 7 (load-upper-immediate), result bits 31:16 equal the immediate and bits 15:0 are zero. Both source operands are ignored.
- R9: mem_addr equals src_a plus the sign-extended immediate, modulo 2^32, for every value of op_sel.
- R10: is_zero is 1 exactly when src_a - src_b equals zero, that is when src_a equals src_b, for every value of op_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation select: 0 add, 1 sub, 2 add-imm, 3 slt, 4 slt-imm, 5 and-imm, 6 or-imm, 7 upper-imm |
| src_a | input | 32 | First register operand, also the base for the address |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field, also the memory offset in bytes |
| result | output | 32 | Result of the selected operation |
| mem_addr | output | 32 | Load/store byte address: base plus the sign-extended offset |
| is_zero | output | 1 | High when src_a minus src_b is zero |

## Verification
All three results are combinational, so each one is due in the same cycle as the inputs that cause it, with zero clock edges of latency. The bench changes inputs only on a falling clock edge and samples the outputs one nanosecond later, well before the next rising edge. Because of this, no check depends on how processes are ordered at an edge. The address and equality outputs are also sampled with unrelated operation selects applied, which shows that they do not depend on op_sel.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDI = 3'd2,
    OP_SLT  = 3'd3,
    OP_SLTI = 3'd4,
    OP_ANDI = 3'd5,
    OP_ORI  = 3'd6,
    OP_LUI  = 3'd7
  } exu_op_e;

  // Signed less-than from the operand sign bits and the sign of a - b.
  // Differing signs: the negative one is smaller. Equal signs: no overflow
  // is possible, so the sign of the difference decides.
  function automatic logic signed_below(input logic a_msb,
                                        input logic b_msb,
                                        input logic diff_msb);
    if (a_msb != b_msb) signed_below = a_msb;
    else                signed_below = diff_msb;
  endfunction

  // Is the operation one that uses the immediate as its second operand?
  function automatic logic uses_sext_imm(input exu_op_e op);
    uses_sext_imm = (op == OP_ADDI) || (op == OP_SLTI);
  endfunction

  // Does the main adder subtract for this operation?
  function automatic logic needs_subtract(input exu_op_e op);
    needs_subtract = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTI);
  endfunction

endpackage

// File: rtl/exu_imm_ext.sv
module exu_imm_ext #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] sext_o,
  output logic [DATA_W-1:0] zext_o,
  output logic [DATA_W-1:0] upper_o
);
  localparam int unsigned PAD_W = DATA_W - IMM_W;

  assign sext_o  = {{PAD_W{imm[IMM_W-1]}}, imm};
  assign zext_o  = {{PAD_W{1'b0}}, imm};
  assign upper_o = {imm, {PAD_W{1'b0}}};

  always_comb begin
    if (PAD_W > 0) begin
      a_r3_sext_upper_uniform: assert ((sext_o[DATA_W-1:IMM_W] == '0) ||
                                       (sext_o[DATA_W-1:IMM_W] == '1));
    end
  end
endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              all_zero
);
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  assign b_eff    = b ^ {DATA_W{sub}};
  assign wide     = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
  assign sum      = wide[DATA_W-1:0];
  assign all_zero = (sum == '0);
endmodule

// File: rtl/exu_logic.sv
module exu_logic #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign and_o[i] = a[i] & b[i];
    assign or_o[i]  = a[i] | b[i];
  end
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] mem_addr,
  output logic              is_zero
);
  localparam int unsigned MSB = DATA_W - 1;

  exu_op_e op;
  assign op = exu_op_e'(op_sel);

  logic [DATA_W-1:0] imm_sext, imm_zext, imm_upper;
  logic [DATA_W-1:0] alu_b, alu_sum, and_val, or_val, cmp_diff;
  logic              alu_sub, alu_zero_unused, addr_zero_unused;
  logic              less_than;

  exu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .imm(imm), .sext_o(imm_sext), .zext_o(imm_zext), .upper_o(imm_upper)
  );

  assign alu_sub = needs_subtract(op);
  assign alu_b   = uses_sext_imm(op) ? imm_sext : src_b;

  exu_addsub #(.DATA_W(DATA_W)) u_alu (
    .a(src_a), .b(alu_b), .sub(alu_sub), .sum(alu_sum), .all_zero(alu_zero_unused)
  );

  exu_addsub #(.DATA_W(DATA_W)) u_cmp (
    .a(src_a), .b(src_b), .sub(1'b1), .sum(cmp_diff), .all_zero(is_zero)
  );

  exu_addsub #(.DATA_W(DATA_W)) u_agu (
    .a(src_a), .b(imm_sext), .sub(1'b0), .sum(mem_addr), .all_zero(addr_zero_unused)
  );

  exu_logic #(.DATA_W(DATA_W)) u_log (
    .a(src_a), .b(imm_zext), .and_o(and_val), .or_o(or_val)
  );

  assign less_than = signed_below(src_a[MSB], alu_b[MSB], alu_sum[MSB]);

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_ADDI: result = alu_sum;
      OP_SLT, OP_SLTI:         result = {{(DATA_W-1){1'b0}}, less_than};
      OP_ANDI:                 result = and_val;
      OP_ORI:                  result = or_val;
      OP_LUI:                  result = imm_upper;
      default:                 result = '0;
    endcase
  end

  always_comb begin
    if ((op == OP_SLT) || (op == OP_SLTI)) begin
      a_r4_slt_boolean: assert (result[DATA_W-1:1] == '0);
    end
    if (op == OP_SLT) begin
      a_r4_slt_equal_is_zero: assert (!(src_a == src_b) || (result == '0));
    end
    if (op == OP_ANDI) begin
      a_r6_andi_upper_clear: assert (result[DATA_W-1:IMM_W] == '0);
    end
    if (op == OP_ORI) begin
      a_r7_ori_upper_keep: assert (result[DATA_W-1:IMM_W] == src_a[DATA_W-1:IMM_W]);
    end
    if (op == OP_LUI) begin
      a_r8_lui_low_zero: assert (result[IMM_W-1:0] == '0);
      a_r8_lui_upper_imm: assert (result[DATA_W-1:IMM_W] == imm);
    end
    a_r9_addr_offset: assert ((mem_addr - src_a) == imm_sext);
    a_r10_zero_equal: assert (is_zero == (src_a == src_b));
  end
endmodule

// File: tb/exu_core_bench.sv
module exu_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel;
  logic [31:0] src_a, src_b;
  logic [15:0] imm;
  logic [31:0] result, mem_addr;
  logic        is_zero;

  int checks = 0;
  int errors = 0;
  int wd_cnt = 0;
  bit done   = 1'b0;

  exu_core u_exu_core (
    .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm(imm),
    .result(result), .mem_addr(mem_addr), .is_zero(is_zero)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) wd_cnt <= 0;
    else     wd_cnt <= wd_cnt + 1;
  end

  function automatic logic [31:0] widen(input logic [15:0] v);
    logic signed [31:0] s;
    s = 32'($signed(v));
    return s;
  endfunction

  task automatic apply(input logic [2:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] i);
    @(negedge clk);
    op_sel = o; src_a = a; src_b = b; imm = i;
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_idle;
    apply(3'd0, 32'd0, 32'd0, 16'd0);
    check("R1 idle result", result, 32'd0);
    check("R10 idle zero flag", {31'd0, is_zero}, 32'd1);
    check("R9 idle address", mem_addr, 32'd0);
  endtask

  task automatic t_add;
    apply(3'd0, 32'd7, 32'd5, 16'h0);
    check("R1 add small", result, 32'd12);
    apply(3'd0, 32'hFFFF_FFFF, 32'd1, 16'h0);
    check("R1 add wraps", result, 32'd0);
  endtask

  task automatic t_sub;
    apply(3'd1, 32'd5, 32'd7, 16'h0);
    check("R2 sub negative", result, 32'hFFFF_FFFE);
    apply(3'd1, 32'h8000_0000, 32'd1, 16'h0);
    check("R2 sub wraps", result, 32'h7FFF_FFFF);
  endtask

  task automatic t_addi;
    apply(3'd2, 32'd100, 32'hDEAD_BEEF, 16'hFFFF);
    check("R3 addi minus one", result, 32'd100 + widen(16'hFFFF));
    apply(3'd2, 32'd100, 32'd0, 16'h7FFF);
    check("R3 addi max positive", result, 32'd32867);
    apply(3'd2, 32'd0, 32'd0, 16'h8000);
    check("R3 addi most negative", result, 32'hFFFF_8000);
  endtask

  task automatic t_slt;
    apply(3'd3, 32'hFFFF_FFFF, 32'd1, 16'h0);
    check("R4 slt neg below pos", result, 32'd1);
    apply(3'd3, 32'd1, 32'hFFFF_FFFF, 16'h0);
    check("R4 slt pos not below neg", result, 32'd0);
    apply(3'd3, 32'd9, 32'd9, 16'h0);
    check("R4 slt equal", result, 32'd0);
    apply(3'd3, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0);
    check("R4 slt extremes", result, 32'd1);
    apply(3'd3, 32'd3, 32'd4, 16'h0);
    check("R4 slt small", result, ($signed(src_a) < $signed(src_b)) ? 32'd1 : 32'd0);
  endtask

  task automatic t_slti;
    apply(3'd4, 32'hFFFF_FFFB, 32'd0, 16'hFFFE);
    check("R5 slti -5 below -2", result, 32'd1);
    apply(3'd4, 32'd3, 32'd1000, 16'h8000);
    check("R5 slti 3 vs -32768", result, 32'd0);
    apply(3'd4, 32'd2, 32'd0, 16'h0010);
    check("R5 slti 2 below 16", result, 32'd1);
  endtask

  task automatic t_andi;
    apply(3'd5, 32'hFFFF_FFFF, 32'd0, 16'h8F0F);
    check("R6 andi zero-extends", result, 32'h0000_8F0F);
    apply(3'd5, 32'h1234_00F0, 32'd0, 16'h0FF0);
    check("R6 andi mask", result, 32'h0000_00F0);
  endtask

  task automatic t_const_build;
    apply(3'd7, 32'h1357_9BDF, 32'h2468_ACE0, 16'hAAAA);
    check("R8 lui places upper", result, 32'hAAAA_0000);
    apply(3'd6, 32'hAAAA_0000, 32'd0, 16'h5555);
    check("R7 ori builds constant", result, 32'hAAAA_5555);
    apply(3'd6, 32'h8000_0001, 32'd0, 16'h8000);
    check("R7 ori keeps upper", result, 32'h8000_8001);
  endtask

  task automatic t_addr;
    apply(3'd7, 32'h0000_1000, 32'd0, 16'd32);
    check("R9 addr element 8", mem_addr, 32'h0000_1020);
    apply(3'd5, 32'h0000_1000, 32'd0, 16'hFFFC);
    check("R9 addr negative offset", mem_addr, 32'h0000_0FFC);
    apply(3'd3, 32'hFFFF_FFF0, 32'd0, 16'h0020);
    check("R9 addr wraps", mem_addr, 32'h0000_0010);
  endtask

  task automatic t_zero;
    apply(3'd7, 32'h0000_1234, 32'h0000_1234, 16'h0);
    check("R10 equal under lui", {31'd0, is_zero}, 32'd1);
    apply(3'd0, 32'h0000_1234, 32'h0000_1235, 16'h0);
    check("R10 differ by one", {31'd0, is_zero}, 32'd0);
    apply(3'd1, 32'h8000_0000, 32'h0000_0000, 16'h0);
    check("R10 differ in msb", {31'd0, is_zero}, 32'd0);
  endtask

  initial begin
    op_sel = 3'd0; src_a = '0; src_b = '0; imm = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle;
    t_add;
    t_sub;
    t_addi;
    t_slt;
    t_slti;
    t_andi;
    t_const_build;
    t_addr;
    t_zero;
    done = 1'b1;
  end

  initial begin
    wait (done || (wd_cnt > 5000));
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule